// File: doc/BRIEF.md
# Conversion Result Threshold Gate

This block sits between a converter's result output and the place where results are stored. Each time a conversion finishes, the result word arrives with a one-cycle valid strobe. The gate compares the word against one or two programmable limits and decides whether to keep it. A kept result is written into the held-result register, and a one-cycle accept strobe is raised. The surrounding logic uses that strobe to set the completion flag, raise an interrupt or request a DMA transfer. A discarded result leaves no trace.

Three control bits select the condition:
- An enable bit turns the compare on. With the compare off, every result is kept.
- A range bit chooses between a single threshold on the first limit and a two-limit window.
- A direction bit sets the sense of a single threshold: below the limit, or at-or-above it. In window mode the same bit instead makes the bounds inclusive.

In window mode the order of the two limits sets the kind of window. When the first limit is at or below the second, results inside the window are kept. When the first limit is above the second, results outside the window are kept.

Every comparison is unsigned. The limits and control bits are sampled in the same cycle as the valid strobe.

Top module: `adc_result_gate`

## Requirements
- R1: With the compare enable bit low, every result presented with valid high is accepted.
- R2: With compare on, range off and the direction bit low, a result is accepted exactly when it is strictly below limit one.
- R3: With compare on, range off and the direction bit high, a result is accepted exactly when it is greater than or equal to limit one.
- R4: With compare on, range on, direction low and limit one <= limit two, a result is accepted exactly when limit one < result < limit two.
- R5: With compare on, range on, direction high and limit one <= limit two, a result is accepted exactly when limit one <= result <= limit two.
- R6: With compare on, range on, direction low and limit one > limit two, a result is accepted exactly when result > limit one or result < limit two.
- R7: With compare on, range on, direction high and limit one > limit two, a result is accepted exactly when result >= limit one or result <= limit two.
- R8: For an accepted result, the accept strobe is high for exactly the one cycle after the valid cycle. In that same cycle the held result shows the accepted word.
- R9: A rejected result, or a cycle without valid, raises no accept strobe and leaves the held result unchanged.
- R10: All comparisons treat the result and the limits as unsigned 16-bit values (for example, 0xFFFF is not below 0x0001).
- R11: During and right after reset, the accept strobe is low and the held result is zero.
- R12: The decision uses the limits and control bits present in the valid cycle. Back-to-back results are each decided on their own settings, and changes in cycles without valid have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | One-cycle strobe marking a finished result |
| resData | input | 16 | Finished conversion result |
| limitOne | input | 16 | First compare limit |
| limitTwo | input | 16 | Second compare limit, used in window mode |
| cmpEnable | input | 1 | Compare function on |
| cmpGreater | input | 1 | Threshold at-or-above / inclusive window bounds |
| cmpRange | input | 1 | Two-limit window mode |
| accStb | output | 1 | One-cycle strobe: the previous result was accepted |
| heldResult | output | 16 | Last accepted result |

## Verification
Two things can land in the same cycle. The decision for one result is issued while the next result is already being compared, and that next result may carry different settings. The bench provokes this with back-to-back valid cycles in which the mode bits and limits change on every word. It then judges each strobe and held value against a model that uses only the settings belonging to that word. Cycles without valid but with altered settings follow; they must leave both outputs untouched.

// File: rtl/adc_gate_pkg.sv
package adc_gate_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } gateStrobes_t;

  // relation flags from datapath to control
  typedef struct packed {
    logic belowOne;
    logic atOne;
    logic belowTwo;
    logic atTwo;
    logic ordered;
  } cmpFlags_t;

  typedef enum logic [2:0] {
    M_PASS,
    M_BELOW,
    M_ATLEAST,
    M_IN_OPEN,
    M_IN_CLOSED,
    M_OUT_OPEN,
    M_OUT_CLOSED
  } gateMode_e;

endpackage

// File: rtl/adc_gate_datapath.sv
module adc_gate_datapath
  import adc_gate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] limitOne,
  input  logic [DATA_W-1:0] limitTwo,
  input  gateStrobes_t      strobes,
  output cmpFlags_t         flags,
  output logic [DATA_W-1:0] heldResult
);
  localparam int NUM_LIMITS = 2;

  logic [DATA_W-1:0] limVec [NUM_LIMITS];
  logic [NUM_LIMITS-1:0] ltVec;
  logic [NUM_LIMITS-1:0] eqVec;

  assign limVec[0] = limitOne;
  assign limVec[1] = limitTwo;

  generate
    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_cmp
      assign ltVec[g] = resData < limVec[g];
      assign eqVec[g] = resData == limVec[g];
    end
  endgenerate

  always_comb begin
    flags.belowOne = ltVec[0];
    flags.atOne    = eqVec[0];
    flags.belowTwo = ltVec[1];
    flags.atTwo    = eqVec[1];
    flags.ordered  = limitOne <= limitTwo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) heldResult <= '0;
    else if (strobes.load) heldResult <= resData;
  end

  // R9: no load, no change
  a_r9_hold_on_reject: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(heldResult));

endmodule

// File: rtl/adc_gate_control.sv
module adc_gate_control
  import adc_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         resValid,
  input  logic         cmpEnable,
  input  logic         cmpGreater,
  input  logic         cmpRange,
  input  cmpFlags_t    flags,
  output gateStrobes_t strobes,
  output logic         accStb
);
  gateMode_e mode;
  logic aboveOne;
  logic aboveTwo;
  logic match;

  always_comb begin
    if (!cmpEnable)     mode = M_PASS;
    else if (!cmpRange) mode = cmpGreater ? M_ATLEAST : M_BELOW;
    else if (flags.ordered) mode = cmpGreater ? M_IN_CLOSED : M_IN_OPEN;
    else                mode = cmpGreater ? M_OUT_CLOSED : M_OUT_OPEN;
  end

  assign aboveOne = !flags.belowOne && !flags.atOne;
  assign aboveTwo = !flags.belowTwo && !flags.atTwo;

  always_comb begin
    unique case (mode)
      M_PASS:       match = 1'b1;
      M_BELOW:      match = flags.belowOne;
      M_ATLEAST:    match = !flags.belowOne;
      M_IN_OPEN:    match = aboveOne && flags.belowTwo;
      M_IN_CLOSED:  match = !flags.belowOne && !aboveTwo;
      M_OUT_OPEN:   match = aboveOne || flags.belowTwo;
      M_OUT_CLOSED: match = !flags.belowOne || !aboveTwo;
      default:      match = 1'b0;
    endcase
  end

  assign strobes.load = resValid && match;

  always_ff @(posedge clk) begin
    if (!rstN) accStb <= 1'b0;
    else       accStb <= strobes.load;
  end

  // R8: strobe only follows a valid cycle
  a_r8_strobe_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    accStb |-> $past(resValid));

  // R1: compare off keeps every result
  a_r1_pass_all: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !cmpEnable) |=> accStb);

  // R2: not below limit one is discarded
  a_r2_below_only: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && cmpEnable && !cmpRange && !cmpGreater && !flags.belowOne) |=> !accStb);

  // R3: below limit one is discarded
  a_r3_atleast_only: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && cmpEnable && !cmpRange && cmpGreater && flags.belowOne) |=> !accStb);

endmodule

// File: rtl/adc_result_gate.sv
module adc_result_gate
  import adc_gate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] limitOne,
  input  logic [DATA_W-1:0] limitTwo,
  input  logic              cmpEnable,
  input  logic              cmpGreater,
  input  logic              cmpRange,
  output logic              accStb,
  output logic [DATA_W-1:0] heldResult
);
  gateStrobes_t strobes;
  cmpFlags_t    flags;

  adc_gate_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .resData    (resData),
    .limitOne   (limitOne),
    .limitTwo   (limitTwo),
    .strobes    (strobes),
    .flags      (flags),
    .heldResult (heldResult)
  );

  adc_gate_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .cmpEnable  (cmpEnable),
    .cmpGreater (cmpGreater),
    .cmpRange   (cmpRange),
    .flags      (flags),
    .strobes    (strobes),
    .accStb     (accStb)
  );

  // R8: accepted word shown with the strobe
  a_r8_store_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    accStb |-> heldResult == $past(resData));

endmodule

// File: tb/test_adc_result_gate.sv
module test_adc_result_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [15:0] resData = '0;
  logic [15:0] limitOne = '0;
  logic [15:0] limitTwo = '0;
  logic        cmpEnable = 1'b0;
  logic        cmpGreater = 1'b0;
  logic        cmpRange = 1'b0;
  logic        accStb;
  logic [15:0] heldResult;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          acc;
    logic [15:0] held;
    string       req;
  } exp_t;

  exp_t        sbQ[$];
  logic [15:0] modelHeld = '0;

  always #4 clk = ~clk;

  adc_result_gate i_adc_result_gate (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resData(resData),
    .limitOne(limitOne), .limitTwo(limitTwo), .cmpEnable(cmpEnable),
    .cmpGreater(cmpGreater), .cmpRange(cmpRange),
    .accStb(accStb), .heldResult(heldResult)
  );

  function automatic bit refAccept(logic [15:0] d, bit en, bit gt, bit rg,
                                   logic [15:0] a, logic [15:0] b);
    if (!en) return 1'b1;
    if (!rg) return gt ? (d >= a) : (d < a);
    if (a <= b) return gt ? (d >= a && d <= b) : (d > a && d < b);
    return gt ? (d >= a || d <= b) : (d > a || d < b);
  endfunction

  task automatic send(bit v, logic [15:0] d, bit en, bit gt, bit rg,
                      logic [15:0] a, logic [15:0] b, string req);
    exp_t e;
    @(negedge clk);
    resValid = v; resData = d; cmpEnable = en; cmpGreater = gt; cmpRange = rg;
    limitOne = a; limitTwo = b;
    e.acc = v && refAccept(d, en, gt, rg, a, b);
    if (e.acc) modelHeld = d;
    e.held = modelHeld;
    e.req = req;
    sbQ.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        exp_t e;
        e = sbQ.pop_front();
        check(accStb == e.acc, e.req, "accept strobe", int'(accStb), int'(e.acc));
        check(heldResult == e.held, e.req, "held result", int'(heldResult), int'(e.held));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(accStb == 1'b0, "R11", "strobe in reset", int'(accStb), 0);
    check(heldResult == 16'h0, "R11", "held in reset", int'(heldResult), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check(accStb == 1'b0, "R11", "strobe after reset", int'(accStb), 0);
    check(heldResult == 16'h0, "R11", "held after reset", int'(heldResult), 0);

    // R1: compare off
    send(1, 16'h1234, 0, 0, 0, 16'h0000, 16'h0000, "R1");
    send(0, 16'h0000, 0, 0, 0, 16'h0000, 16'h0000, "R9");
    send(1, 16'hFFFF, 0, 1, 1, 16'h0005, 16'h0001, "R1");
    send(0, 16'h0000, 0, 0, 0, 16'h0000, 16'h0000, "R9");

    // R2: strictly below limit one
    send(1, 16'd99,  1, 0, 0, 16'd100, 16'd0, "R2");
    send(1, 16'd100, 1, 0, 0, 16'd100, 16'd0, "R2");
    send(1, 16'd101, 1, 0, 0, 16'd100, 16'd0, "R2");
    send(0, 16'd7,   1, 0, 0, 16'd100, 16'd0, "R9");

    // R3: at or above limit one
    send(1, 16'd99,  1, 1, 0, 16'd100, 16'd0, "R3");
    send(1, 16'd100, 1, 1, 0, 16'd100, 16'd0, "R3");
    send(1, 16'd101, 1, 1, 0, 16'd100, 16'd0, "R3");

    // R4 / R5: window inside
    for (int i = 0; i < 6; i++) begin
      logic [15:0] pts [6] = '{16'd50, 16'd100, 16'd101, 16'd199, 16'd200, 16'd250};
      send(1, pts[i], 1, 0, 1, 16'd100, 16'd200, "R4");
      send(1, pts[i] ^ 16'h0000, 1, 1, 1, 16'd100, 16'd200, "R5");
    end
    // equal limits: open window empty, closed window single point
    send(1, 16'd300, 1, 0, 1, 16'd300, 16'd300, "R4");
    send(1, 16'd300, 1, 1, 1, 16'd300, 16'd300, "R5");

    // R6 / R7: window outside
    for (int i = 0; i < 6; i++) begin
      logic [15:0] pts [6] = '{16'd50, 16'd100, 16'd101, 16'd150, 16'd200, 16'd201};
      send(1, pts[i], 1, 0, 1, 16'd200, 16'd100, "R6");
      send(1, pts[i], 1, 1, 1, 16'd200, 16'd100, "R7");
    end

    // R10: unsigned comparisons
    send(1, 16'hFFFF, 1, 0, 0, 16'h0001, 16'h0000, "R10");
    send(1, 16'h8000, 1, 1, 0, 16'h7FFF, 16'h0000, "R10");
    send(1, 16'h7FFF, 1, 1, 0, 16'h8000, 16'h0000, "R10");
    send(1, 16'h9000, 1, 1, 1, 16'h8000, 16'hA000, "R10");

    // R12: back-to-back with changing settings, then idle churn
    send(1, 16'h0010, 1, 0, 0, 16'h0020, 16'h0000, "R12");
    send(1, 16'h0030, 1, 0, 0, 16'h0020, 16'h0000, "R12");
    send(1, 16'h0030, 1, 1, 0, 16'h0020, 16'h0000, "R12");
    send(1, 16'h0005, 1, 0, 1, 16'h0040, 16'h0010, "R12");
    send(1, 16'h0025, 1, 1, 1, 16'h0010, 16'h0040, "R12");
    send(0, 16'h0001, 0, 0, 0, 16'h0000, 16'h0000, "R12");
    send(0, 16'hFFFF, 1, 1, 1, 16'h0000, 16'hFFFF, "R12");
    send(1, 16'hABCD, 1, 0, 0, 16'h0000, 16'h0000, "R9");
    send(0, 16'h0000, 0, 0, 0, 16'h0000, 16'h0000, "R8");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule